// File: doc/BRIEF.md
# Endian Byte Lane Swapper

This block sits in the data path between a little-endian local processor bus and a big-endian backplane bus. Each beat carries a 32-bit data word, a transfer width code, the backplane address of the transfer and an endian-mode select. The block steers the byte lanes of the word to suit the selected mode and width, and registers the result toward the far side. The steering is its own inverse, so one instance serves both the write path (local to backplane) and the read path (backplane to local).

When big-endian steering is chosen, the backplane address must be aligned to the transfer width. A misaligned beat is still forwarded with its steered data, but it carries a flag that marks the data as scrambled. Only the backplane address is checked. The local processor address never reaches this block and so can never raise the flag. Values wider than 32 bits are not handled in hardware. Such a value must be moved as two separate 32-bit little-endian beats.

Both ends of the data path use valid/ready. A beat moves when valid and ready are high on the same rising edge. The output stage holds one beat. The block accepts a new beat when that stage is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the beat on the output stays frozen.

Top module: `lane_steer`

## Requirements
- R1: With `in_big` = 0, the data passes through unchanged for every width code.
- R2: With `in_big` = 1 and width code 1 (D16), the two bytes inside each 16-bit half are exchanged. Output bits [7:0] take input [15:8], [15:8] take [7:0], [23:16] take [31:24], and [31:24] take [23:16].
- R3: With `in_big` = 1 and width code 2 (D32), all four bytes are reversed. Output byte k takes input byte 3-k, where byte k is bits [8k+7:8k].
- R4: With width code 0 (D08), the data passes through unchanged in both modes. The byte stays on the lane that the address selects.
- R5: Width code 3 is reserved. It behaves like D08: the data passes through unchanged and the flag is never raised.
- R6: `out_misalign` is 1 on a beat taken with `in_big` = 1 and either width code 1 with address bit 0 set, or width code 2 with address bits [1:0] not zero. The steered data is forwarded anyway, and the flag is only ever high together with `out_valid`.
- R7: `out_misalign` is 0 for every beat taken with `in_big` = 0 or with width code 0. Address bits above [1:0] never affect the flag or the data.
- R8: Steering is its own inverse. Passing a steered word through again with the same mode and width gives back the original word.
- R9: `in_ready` is high when the output stage is empty or `out_ready` is high. A beat accepted on one edge appears on the output after that edge. While `out_valid` is high and `out_ready` is low, `out_data` and `out_misalign` hold their values.
- R10: During reset and directly after it, `out_valid` and `out_misalign` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 32 | Data word to steer |
| in_width | input | 2 | Width code: 0 D08, 1 D16, 2 D32, 3 reserved |
| in_addr | input | 32 | Backplane address of the transfer |
| in_big | input | 1 | 1 selects big-endian steering |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 32 | Steered data word |
| out_misalign | output | 1 | Backplane address misaligned for this beat |

## Verification
The bench aims at beats where a mix-up between D16 and D32 steering would show, such as D16 data with distinct upper bytes. A design that mixed them up would put bytes on the wrong half of the word. Odd and unaligned addresses are sent in both modes and at every width. A design that checked alignment in little-endian mode, or on D08 and reserved widths, would raise false flags. A design that looked only at address bit 0 would miss D32 beats at address offset 2. Long runs with `out_ready` held low test that a stalled beat stays frozen and is neither lost nor duplicated. Feeding steered output back in shows whether the steering is its own inverse.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    XW_BYTE = 2'd0,
    XW_HALF = 2'd1,
    XW_WORD = 2'd2,
    XW_RSVD = 2'd3
  } xfer_width_e;
endpackage

// File: rtl/lane_swap.sv
module lane_swap
  import lane_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] din,
  input  logic [1:0]         width,
  input  logic               big,
  output logic [8*LANES-1:0] dout
);
  localparam int DW = 8 * LANES;

  xfer_width_e wcode;
  assign wcode = xfer_width_e'(width);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HALF_SRC = i ^ 1;
    localparam int WORD_SRC = LANES - 1 - i;
    always_comb begin
      dout[8*i +: 8] = din[8*i +: 8];
      if (big) begin
        case (wcode)
          XW_HALF: dout[8*i +: 8] = din[8*HALF_SRC +: 8];
          XW_WORD: dout[8*i +: 8] = din[8*WORD_SRC +: 8];
          default: dout[8*i +: 8] = din[8*i +: 8];
        endcase
      end
    end
  end

  // A lane permutation can neither create nor drop set bits.
  always_comb begin
    if (!$isunknown({din, width, big}))
      AST_BITS_KEPT: assert ($countones(dout) == $countones(din)); // R3
  end

  logic [DW-1:0] unused_chk;
  assign unused_chk = dout;
endmodule

// File: rtl/align_check.sv
module align_check
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        width,
  input  logic              big,
  output logic              misalign
);
  localparam int LOW_W = 2;

  logic [LOW_W-1:0] low;
  assign low = addr[LOW_W-1:0];

  always_comb begin
    misalign = 1'b0;
    if (big) begin
      case (xfer_width_e'(width))
        XW_HALF: misalign = low[0];
        XW_WORD: misalign = |low;
        default: misalign = 1'b0;
      endcase
    end
  end

  logic [ADDR_W-1:0] unused_hi;
  assign unused_hi = addr;
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         s_flag,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         m_flag
);
  logic take;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_flag  <= 1'b0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_data  <= s_data;
      m_flag  <= s_flag;
    end else if (m_ready) begin
      m_valid <= 1'b0;
      m_flag  <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_flag))); // R9
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> m_valid); // R9
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [8*LANES-1:0] in_data,
  input  logic [1:0]        in_width,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_big,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [8*LANES-1:0] out_data,
  output logic              out_misalign
);
  localparam int DW = 8 * LANES;

  logic [DW-1:0] steered;
  logic          bad_align;

  lane_swap #(.LANES(LANES)) u_swap (
    .din   (in_data),
    .width (in_width),
    .big   (in_big),
    .dout  (steered)
  );

  align_check #(.ADDR_W(ADDR_W)) u_align (
    .addr     (in_addr),
    .width    (in_width),
    .big      (in_big),
    .misalign (bad_align)
  );

  out_stage #(.W(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (steered),
    .s_flag  (bad_align),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data),
    .m_flag  (out_misalign)
  );

  AST_LITTLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_big) |=> !out_misalign); // R7
  AST_BYTE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_width == 2'd0) |=> !out_misalign); // R7
  AST_RSVD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_width == 2'd3) |=> !out_misalign); // R5
  AST_ODD_HALF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_big && in_width == 2'd1 && in_addr[0]) |=> out_misalign); // R6
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_misalign |-> out_valid); // R6
endmodule

// File: tb/test_lane_steer.sv
module test_lane_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_width = '0;
  logic [31:0] in_addr = '0;
  logic        in_big = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_misalign;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit          mv = 0;
  logic [31:0] md = '0;
  bit          mf = 0;
  string       dtag = "R1";
  string       ftag = "R7";

  always #4 clk = ~clk;

  lane_steer i_lane_steer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_width(in_width), .in_addr(in_addr), .in_big(in_big),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_misalign(out_misalign)
  );

  function automatic logic [31:0] ref_steer(logic [31:0] d, logic [1:0] w, bit big);
    if (!big || w == 2'd0 || w == 2'd3) return d;
    if (w == 2'd1) return ((d & 32'h00FF00FF) << 8) | ((d >> 8) & 32'h00FF00FF);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic bit ref_flag(logic [31:0] a, logic [1:0] w, bit big);
    if (!big) return 0;
    if (w == 2'd1) return a % 2 != 0;
    if (w == 2'd2) return a % 4 != 0;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // advance one clock: update model at the edge, compare half a cycle later
  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      mv = 0; mf = 0;
    end else if (in_valid && (!mv || out_ready)) begin
      mv = 1;
      md = ref_steer(in_data, in_width, in_big);
      mf = ref_flag(in_addr, in_width, in_big);
      if (!in_big) dtag = "R1";
      else if (in_width == 2'd0) dtag = "R4";
      else if (in_width == 2'd3) dtag = "R5";
      else if (in_width == 2'd1) dtag = "R2";
      else dtag = "R3";
      ftag = (in_big && (in_width == 2'd1 || in_width == 2'd2)) ? "R6" : "R7";
    end else if (out_ready) begin
      mv = 0; mf = 0;
    end
    @(negedge clk);
    chk(out_valid == mv, "R9", "out_valid", 32'(out_valid), 32'(mv));
    chk(in_ready == (!mv || out_ready), "R9", "in_ready", 32'(in_ready), 32'(!mv || out_ready));
    if (mv) begin
      chk(out_data == md, dtag, "out_data", out_data, md);
      chk(out_misalign == mf, ftag, "out_misalign", 32'(out_misalign), 32'(mf));
    end else begin
      chk(out_misalign == 1'b0, "R6", "flag without valid", 32'(out_misalign), 32'd0);
    end
  endtask

  task automatic beat(logic [31:0] d, logic [1:0] w, logic [31:0] a, bit big);
    in_valid = 1; in_data = d; in_width = w; in_addr = a; in_big = big; out_ready = 1;
    tick();
    in_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] y;
    @(negedge clk);
    chk(out_valid == 0 && out_misalign == 0 && in_ready == 1, "R10", "reset outputs",
        {29'd0, out_valid, out_misalign, in_ready}, 32'd1);
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(out_valid == 0 && in_ready == 1, "R10", "after reset",
        {30'd0, out_valid, in_ready}, 32'd1);

    // directed: each mode and width, aligned and misaligned
    beat(32'h11223344, 2'd2, 32'h1000, 1);  // R3
    beat(32'h11223344, 2'd1, 32'h1002, 1);  // R2
    beat(32'hA1B2C3D4, 2'd1, 32'h1001, 1);  // R6 odd D16
    beat(32'hA1B2C3D4, 2'd2, 32'h1002, 1);  // R6 D32 offset 2
    beat(32'hA1B2C3D4, 2'd2, 32'h1001, 1);  // R6 D32 offset 1
    beat(32'hCAFEF00D, 2'd2, 32'h1003, 0);  // R1 R7
    beat(32'hCAFEF00D, 2'd1, 32'h1001, 0);  // R1 R7
    beat(32'h000000EE, 2'd0, 32'h2003, 1);  // R4 R7
    beat(32'h55AA33CC, 2'd3, 32'h2003, 1);  // R5
    beat(32'h0BADBEEF, 2'd2, 32'hFFFF_FFFC, 1); // R7 high bits ignored

    // R8: steered output fed back returns the original
    for (int w = 1; w <= 2; w++) begin
      beat(32'h89ABCDEF, 2'(w), 32'h0, 1);
      y = out_data;
      beat(y, 2'(w), 32'h0, 1);
      chk(out_data == 32'h89ABCDEF, "R8", "round trip", out_data, 32'h89ABCDEF);
    end

    // R9: long stall holds the beat
    in_valid = 1; in_data = 32'h01020304; in_width = 2'd2; in_addr = 32'h5; in_big = 1;
    out_ready = 0;
    tick();
    in_data = 32'hFFFFFFFF; in_width = 2'd0;
    repeat (6) tick();
    out_ready = 1;
    tick();
    in_valid = 0;
    tick();

    // random traffic with back-pressure
    for (int n = 0; n < 4000; n++) begin
      in_valid  = ($urandom % 10) < 7;
      out_ready = ($urandom % 10) < 6;
      in_data   = $urandom;
      in_width  = 2'($urandom);
      in_addr   = $urandom;
      in_big    = 1'($urandom);
      tick();
    end
    in_valid = 0; out_ready = 1;
    repeat (2) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule